// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This unit watches the asynchronous hot-plug detect line of a display transmitter. It brings the line into the clock domain through a synchronizer chain and removes glitches with a debounce filter whose length is set in a register. The debounced level can be read at any time and is also driven on a dedicated output. Each change of the debounced level latches an event: a connect event when the level rises and a disconnect event when it falls. A separate core interrupt line from the transmitter controller is merged into the same status word.

Every status bit stays set until software writes a 1 to that bit position. A per-source enable register chooses which pending bits drive the single interrupt output. Software reaches the registers through a simple port with a word index, write data, a write strobe and a read strobe. Read data is registered.

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset the status word is 0, the enable word is 0, `irq_o` is 0, the debounced level is 0 and the filter register holds `FILT_RESET` (default 16).
- R2: A change on `hpd_i` reaches the debounced level exactly N+2 clock edges after it is applied, where N is the filter value: two edges for the synchronizer, then N consecutive samples that differ from the current level. A pulse held for fewer than N samples leaves the level and the status word unchanged.
- R3: The debounced level is readable as bit 0 of word index 0 and on `hpd_level_o`. Writes to index 0 are ignored.
- R4: A 0-to-1 change of the debounced level sets status bit 1 (connect). A 1-to-0 change sets status bit 2 (disconnect). Both bits can be pending at the same time.
- R5: `core_irq_i` is sampled as a level. It sets status bit 0 on every clock edge at which it is high.
- R6: A write to word index 2 clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R7: When a source sets a status bit on the same edge as a write that clears it, the bit stays set.
- R8: Word index 3, bits [2:0], is the enable word, with 1 enabling a source. `irq_o` is the OR of status AND enable. A disabled source still latches and can still be read.
- R9: Word index 1 holds the filter value in its low `FILT_W` bits and reads it back. A filter value of 0 acts the same as a value of 1.
- R10: `rd_data_o` is loaded on the edge where `rd_en_i` is high and holds its value otherwise. A read of an unmapped index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| hpd_i | input | 1 | Asynchronous hot-plug detect line |
| core_irq_i | input | 1 | Core interrupt request, level |
| addr_i | input | ADDR_W | Register word index |
| wr_data_i | input | DATA_W | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Registered read data |
| hpd_level_o | output | 1 | Debounced hot-plug level |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench measures the filter delay to the exact edge, once for a nonzero filter value and once for zero. A counter that is off by one, or a zero value that never lets the level change, shows up as a level that flips one edge early or late, or never flips. A glitch one sample shorter than the filter must leave both the level and the status word alone; a filter that counts non-consecutive samples would latch a false connect. The bench also holds the core line high while it clears bit 0, so a design that lets the clear win loses the event, and it writes zeros and partial masks to the clear register to catch a design that clears by writing rather than by writing ones.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
   // status / enable bit positions (software decodes these)
   localparam int unsigned SRC_CORE = 0;
   localparam int unsigned SRC_RISE = 1;
   localparam int unsigned SRC_FALL = 2;
   localparam int unsigned NSRC     = 3;

   // register word indices
   localparam int unsigned IDX_LEVEL  = 0;
   localparam int unsigned IDX_FILTER = 1;
   localparam int unsigned IDX_STATUS = 2;
   localparam int unsigned IDX_ENABLE = 3;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= async_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= {chain_q[STAGES-2:0], async_i};
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpd_debounce.sv
module hpd_debounce #(
   parameter int unsigned FILT_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sample_i,
   input  logic [FILT_W-1:0] limit_i,
   output logic              level_o,
   output logic              rise_o,
   output logic              fall_o
);
   localparam int unsigned CNT_W = FILT_W + 1;

   logic [FILT_W-1:0] run_q;
   logic              level_q;
   logic              rise_q;
   logic              fall_q;
   logic [CNT_W-1:0]  run_next;
   logic              differs;
   logic              accept;

   assign differs  = (sample_i != level_q);
   assign run_next = {1'b0, run_q} + CNT_W'(1);
   assign accept   = differs && (run_next >= {1'b0, limit_i});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= '0;
         level_q <= 1'b0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         rise_q <= accept &&  sample_i;
         fall_q <= accept && !sample_i;
         if (accept) begin
            level_q <= sample_i;
            run_q   <= '0;
         end else if (differs) begin
            run_q   <= run_next[FILT_W-1:0];
         end else begin
            run_q   <= '0;
         end
      end
   end

   assign level_o = level_q;
   assign rise_o  = rise_q;
   assign fall_o  = fall_q;

   AST_LEVEL_NEEDS_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(level_q) |-> ($past(sample_i) != $past(level_q))) else $error("level moved without a differing sample"); // R2
   AST_RISE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_q |-> level_q) else $error("connect event with level low"); // R4
   AST_FALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_q |-> !level_q) else $error("disconnect event with level high"); // R4
endmodule

// File: rtl/hpd_status_bank.sv
module hpd_status_bank #(
   parameter int unsigned NSRC = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   input  logic            en_wr_i,
   input  logic [NSRC-1:0] en_data_i,
   output logic [NSRC-1:0] status_o,
   output logic [NSRC-1:0] enable_o,
   output logic            irq_o
);
   logic [NSRC-1:0] status_q;
   logic [NSRC-1:0] enable_q;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_bit
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       status_q[i] <= 1'b0;
            else if (set_i[i]) status_q[i] <= 1'b1;
            else if (clr_i[i]) status_q[i] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      enable_q <= '0;
      else if (en_wr_i) enable_q <= en_data_i;
   end

   assign status_o = status_q;
   assign enable_o = enable_q;
   assign irq_o    = |(status_q & enable_q);

   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i))) else $error("set event lost"); // R7
   AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(clr_i & ~set_i)) |=> ((status_q & $past(clr_i & ~set_i)) == '0)) else $error("clear ignored"); // R6
   AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i == '0) |=> ((status_q & ~$past(status_q)) == '0)) else $error("bit set without source"); // R5
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
   import hpd_irq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned FILT_W      = 8,
   parameter int unsigned FILT_RESET  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hpd_i,
   input  logic              core_irq_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              hpd_level_o,
   output logic              irq_o
);
   localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(IDX_LEVEL);
   localparam logic [ADDR_W-1:0] A_FILTER = ADDR_W'(IDX_FILTER);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(IDX_STATUS);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(IDX_ENABLE);

   initial begin
      assert (DATA_W >= FILT_W && DATA_W >= NSRC) else $error("DATA_W too narrow");
      assert (FILT_W >= 1 && FILT_W <= 24) else $error("FILT_W out of range");
      assert (FILT_RESET >= 1 && FILT_RESET < (1 << FILT_W)) else $error("FILT_RESET out of range");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (ADDR_W >= 2) else $error("ADDR_W too narrow");
   end

   logic              hpd_sync;
   logic              level;
   logic              rise;
   logic              fall;
   logic [FILT_W-1:0] filt_q;
   logic [NSRC-1:0]   set_v;
   logic [NSRC-1:0]   clr_v;
   logic [NSRC-1:0]   status;
   logic [NSRC-1:0]   enable;
   logic              en_wr;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rd_q;

   hpd_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (hpd_i),
      .sync_o  (hpd_sync)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             filt_q <= FILT_W'(FILT_RESET);
      else if (wr_en_i && addr_i == A_FILTER)  filt_q <= wr_data_i[FILT_W-1:0];
   end

   hpd_debounce #(.FILT_W(FILT_W)) deb_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (hpd_sync),
      .limit_i  (filt_q),
      .level_o  (level),
      .rise_o   (rise),
      .fall_o   (fall)
   );

   always_comb begin
      set_v           = '0;
      set_v[SRC_CORE] = core_irq_i;
      set_v[SRC_RISE] = rise;
      set_v[SRC_FALL] = fall;
   end

   assign clr_v = (wr_en_i && addr_i == A_STATUS) ? wr_data_i[NSRC-1:0] : '0;
   assign en_wr = wr_en_i && addr_i == A_ENABLE;

   hpd_status_bank #(.NSRC(NSRC)) bank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_v),
      .clr_i     (clr_v),
      .en_wr_i   (en_wr),
      .en_data_i (wr_data_i[NSRC-1:0]),
      .status_o  (status),
      .enable_o  (enable),
      .irq_o     (irq_o)
   );

   always_comb begin
      rd_mux = '0;
      case (addr_i)
         A_LEVEL:  rd_mux = DATA_W'(level);
         A_FILTER: rd_mux = DATA_W'(filt_q);
         A_STATUS: rd_mux = DATA_W'(status);
         A_ENABLE: rd_mux = DATA_W'(enable);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rd_q <= '0;
      else if (rd_en_i) rd_q <= rd_mux;
   end

   assign rd_data_o   = rd_q;
   assign hpd_level_o = level;

   AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> ($past(core_irq_i || rise || fall) || $past(en_wr))) else $error("irq rose without cause"); // R8
   AST_RD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rd_data_o)) else $error("read data moved without strobe"); // R10
endmodule

// File: tb/hpd_irq_unit_tb_top.sv
module hpd_irq_unit_tb_top;
   localparam int AW = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hpd = 1'b0;
   logic          core = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rdata;
   logic          level;
   logic          irq;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   hpd_irq_unit dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .hpd_i       (hpd),
      .core_irq_i  (core),
      .addr_i      (addr),
      .wr_data_i   (wdata),
      .wr_en_i     (wr_en),
      .rd_en_i     (rd_en),
      .rd_data_o   (rdata),
      .hpd_level_o (level),
      .irq_o       (irq)
   );

   // register table: op (1 = write, 0 = read-and-compare), index, data
   localparam int NV = 10;
   localparam bit        V_WR  [NV] = '{1, 0, 1, 0, 1, 0, 0, 1, 0, 1};
   localparam bit [3:0]  V_IDX [NV] = '{1, 1, 3, 3, 1, 1, 9, 0, 0, 3};
   localparam bit [31:0] V_DAT [NV] = '{32'h5, 32'h5, 32'h6, 32'h6, 32'h0, 32'h0,
                                        32'h0, 32'h1, 32'h0, 32'h0};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      addr = a; rd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      check("R1 irq", irq, 0);
      check("R1 level", level, 0);
      rd(1, r); check("R1 filter", r, 16);
      rd(2, r); check("R1 status", r, 0);
      rd(3, r); check("R1 enable", r, 0);

      // table walk: R9 filter, R8 enable, R10 unmapped, R3 write ignored
      for (int i = 0; i < NV; i++) begin
         if (V_WR[i]) wr(V_IDX[i], V_DAT[i]);
         else begin
            rd(V_IDX[i], r);
            check($sformatf("R9/R8/R10/R3 vector %0d", i), r, V_DAT[i]);
         end
      end

      // R2 glitch shorter than filter
      wr(1, 4);
      hpd = 1'b1; tick(3); hpd = 1'b0;
      tick(8);
      check("R2 glitch level", level, 0);
      rd(2, r); check("R2 glitch status", r, 0);

      // R2 exact delay with filter 4
      hpd = 1'b1;
      tick(5); check("R2 level early", level, 0);
      tick(1); check("R2 level on time", level, 1);
      rd(0, r); check("R3 level read", r, 1);
      tick(2);
      rd(2, r); check("R4 connect latched", r, 32'h2);
      check("R8 masked no irq", irq, 0);
      wr(3, 32'h2);
      check("R8 enabled irq", irq, 1);

      // R4 disconnect while connect pending
      hpd = 1'b0; tick(10);
      rd(2, r); check("R4 both pending", r, 32'h6);

      // R6 write-one-to-clear
      wr(2, 32'h0); rd(2, r); check("R6 zero write keeps", r, 32'h6);
      wr(2, 32'h2); rd(2, r); check("R6 partial clear", r, 32'h4);
      check("R8 irq drops", irq, 0);
      wr(2, 32'h4); rd(2, r); check("R6 clear rest", r, 32'h0);

      // R5 core one-cycle pulse
      core = 1'b1; tick(1); core = 1'b0;
      rd(2, r); check("R5 core latched", r, 32'h1);
      wr(3, 32'h1); check("R8 core irq", irq, 1);

      // R7 clear while core still high
      core = 1'b1;
      wr(2, 32'h1);
      rd(2, r); check("R7 set wins", r, 32'h1);
      core = 1'b0; tick(1);
      wr(2, 32'h1); rd(2, r); check("R7 clear after drop", r, 32'h0);
      check("R8 irq off", irq, 0);

      // R9 filter 0 acts as 1
      wr(1, 0);
      hpd = 1'b1;
      tick(2); check("R9 zero filter early", level, 0);
      tick(1); check("R9 zero filter on time", level, 1);
      tick(3);
      rd(2, r); check("R4 connect with zero filter", r, 32'h2);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule